// File: doc/BRIEF.md
# Packet Bus Receive Word Unpacker

This block sits on the receive side of a single-channel packet bus. The bus carries packets as 32-bit words. A valid strobe qualifies each word, and each word also carries a start-of-packet flag, an end-of-packet flag, a two-bit word-modulo code and a parity bit. The block takes one word at a time into a one-word holding register. It then releases the valid bytes one per cycle on a byte stream with ready/valid flow control. The first byte of a packet is tagged as first and the final byte as last.

While it accepts words, the block checks parity and packet framing and raises three sticky error flags. Each flag is cleared by a one-cycle clear pulse. A narrow mode selects an 8-bit lane, in which only the low byte of the bus carries data. The block has a single channel, moves whole packets, and has no address decode. The bus error input is taken to be always low, so it has no pin.

Top module: `pkt_rx_unpacker`

## Requirements
- R1: A word is taken in on a rising edge where `inValid` and `inReady` are both high. `inReady` is high exactly when no word is being held. Once a word is taken in, `inReady` stays low until the last byte of that word has been handed off.
- R2: Bytes leave most-significant first, starting with bits 31:24. One byte moves per cycle in which `outValid` and `outReady` are both high. While `outReady` is low, `outByte`, `outFirst` and `outLast` hold steady.
- R3: In 32-bit mode, a word taken in with `inEop` low yields four bytes. A word with `inEop` high yields 4 minus `inMod` bytes: code 0 gives bits 31:0, 1 gives bits 31:8, 2 gives bits 31:16, and 3 gives bits 31:24 only.
- R4: In 32-bit mode, a word taken in with `inEop` low and a nonzero `inMod` sets `protoErr`.
- R5: With `laneMode8` high, each word taken in yields exactly one byte, taken from bits 7:0. In this mode `inMod` is ignored and never sets `protoErr`.
- R6: `outFirst` is high on the first byte of a word taken in with `inSop` high. `outLast` is high on the final byte of a word taken in with `inEop` high. A single word may carry both flags.
- R7: Parity is odd by default and even when `EVEN_PARITY` is 1. It covers all 32 data bits in 32-bit mode and bits 7:0 in 8-bit mode. A mismatch on a word taken in sets `parityErr`.
- R8: `framingErr` is set by a word taken in with `inSop` high while a packet is open. It is also set by a word taken in with `inSop` low while no packet is open. A start flag always opens a new packet. A word with no open packet and no start flag produces no bytes. An end flag closes the packet.
- R9: The error flags are sticky. `errClear` bit 0 clears `parityErr`, bit 1 clears `framingErr` and bit 2 clears `protoErr`. When a flag is set and cleared in the same cycle, the set wins.
- R10: During reset, `outValid` is low, `inReady` is high, all error flags are low and no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneMode8 | input | 1 | 1 selects the 8-bit lane on bits 7:0 |
| inData | input | 32 | Bus data word |
| inValid | input | 1 | Bus word valid |
| inSop | input | 1 | Word starts a packet |
| inEop | input | 1 | Word ends a packet |
| inMod | input | 2 | Count of unused low bytes on the final word |
| inParity | input | 1 | Parity bit for the word |
| inReady | output | 1 | Block can take a word |
| outByte | output | 8 | Output byte |
| outValid | output | 1 | Output byte valid |
| outFirst | output | 1 | First byte of a packet |
| outLast | output | 1 | Final byte of a packet |
| outReady | input | 1 | Downstream takes the byte |
| errClear | input | 3 | Clear pulses for the error flags |
| parityErr | output | 1 | Sticky parity error |
| framingErr | output | 1 | Sticky framing error |
| protoErr | output | 1 | Sticky modulo-code error |

## Verification
Two things can fall in the same cycle: an error flag being set by a word as it is taken in, and the clear pulse for that same flag. The random stimulus produces frequent parity, framing and modulo faults while also driving clear pulses at random. Collisions therefore occur many times, in both lane modes. A behavioural reference model applies the set-over-clear rule, and the bench compares every flag against it on every cycle. This shows that a collision leaves the flag high and that a clear with no new fault drops it.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  localparam int ERR_PARITY = 0;
  localparam int ERR_FRAME  = 1;
  localparam int ERR_PROTO  = 2;
  localparam int ERR_COUNT  = 3;

  typedef struct packed {
    logic load;       // capture the incoming word into the holding register
    logic pop;        // one byte handed off downstream
    logic markFirst;  // captured word opens a packet
    logic markLast;   // captured word closes a packet
  } ctlStrobe_t;

endpackage

// File: rtl/pkt_rx_ctrl.sv
module pkt_rx_ctrl
  import pkt_rx_pkg::*;
#(
  parameter int MOD_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 laneMode8,
  input  logic                 inValid,
  input  logic                 inSop,
  input  logic                 inEop,
  input  logic [MOD_W-1:0]     inMod,
  input  logic                 parityBad,
  input  logic                 bufValid,
  input  logic                 outReady,
  input  logic [ERR_COUNT-1:0] errClear,
  output logic                 inReady,
  output ctlStrobe_t           ctl,
  output logic [ERR_COUNT-1:0] errFlags
);

  logic pktOpen;
  logic accept;
  logic orphan;
  logic [ERR_COUNT-1:0] errSet;

  assign inReady = !bufValid;
  assign accept  = inValid && inReady;
  assign orphan  = !inSop && !pktOpen;

  always_comb begin
    ctl.load      = accept && !orphan;
    ctl.pop       = bufValid && outReady;
    ctl.markFirst = inSop;
    ctl.markLast  = inEop;
  end

  always_comb begin
    errSet             = '0;
    errSet[ERR_PARITY] = accept && parityBad;
    // start while open, or no start while closed
    errSet[ERR_FRAME]  = accept && (inSop == pktOpen);
    errSet[ERR_PROTO]  = accept && !laneMode8 && !inEop && (inMod != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktOpen  <= 1'b0;
      errFlags <= '0;
    end else begin
      if (ctl.load) pktOpen <= !inEop;
      errFlags <= (errFlags & ~errClear) | errSet;
    end
  end

endmodule

// File: rtl/pkt_rx_datapath.sv
module pkt_rx_datapath
  import pkt_rx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int EVEN_PARITY = 0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         laneMode8,
  input  logic [DATA_W-1:0]            inData,
  input  logic [$clog2(DATA_W/8)-1:0]  inMod,
  input  logic                         inParity,
  input  ctlStrobe_t                   ctl,
  output logic                         parityBad,
  output logic                         bufValid,
  output logic [7:0]                   outByte,
  output logic                         outFirst,
  output logic                         outLast
);

  localparam int BYTES = DATA_W / 8;
  localparam int IDX_W = $clog2(BYTES);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(BYTES - 1);

  logic [DATA_W-1:0] word;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  lastIdx;
  logic              firstFlag;
  logic              lastFlag;
  logic              sel8;
  logic [7:0]        lanes [BYTES];
  logic              dataPar;

  // lane 0 is the most significant byte
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lanes[g] = word[8*(BYTES-1-g) +: 8];
  end

  assign dataPar   = laneMode8 ? ^inData[7:0] : ^inData;
  assign parityBad = ((dataPar ^ inParity) == 1'b1) == (EVEN_PARITY != 0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValid  <= 1'b0;
      word      <= '0;
      idx       <= '0;
      lastIdx   <= '0;
      firstFlag <= 1'b0;
      lastFlag  <= 1'b0;
      sel8      <= 1'b0;
    end else if (ctl.load) begin
      bufValid  <= 1'b1;
      word      <= inData;
      idx       <= '0;
      firstFlag <= ctl.markFirst;
      lastFlag  <= ctl.markLast;
      sel8      <= laneMode8;
      if (laneMode8)        lastIdx <= '0;
      else if (ctl.markLast) lastIdx <= TOP_IDX - inMod;
      else                   lastIdx <= TOP_IDX;
    end else if (ctl.pop) begin
      if (idx == lastIdx) bufValid <= 1'b0;
      else                idx      <= idx + 1'b1;
    end
  end

  assign outByte  = sel8 ? lanes[BYTES-1] : lanes[idx];
  assign outFirst = bufValid && firstFlag && (idx == '0);
  assign outLast  = bufValid && lastFlag && (idx == lastIdx);

endmodule

// File: rtl/pkt_rx_unpacker.sv
module pkt_rx_unpacker
  import pkt_rx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int EVEN_PARITY = 0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         laneMode8,
  input  logic [DATA_W-1:0]            inData,
  input  logic                         inValid,
  input  logic                         inSop,
  input  logic                         inEop,
  input  logic [$clog2(DATA_W/8)-1:0]  inMod,
  input  logic                         inParity,
  output logic                         inReady,
  output logic [7:0]                   outByte,
  output logic                         outValid,
  output logic                         outFirst,
  output logic                         outLast,
  input  logic                         outReady,
  input  logic [2:0]                   errClear,
  output logic                         parityErr,
  output logic                         framingErr,
  output logic                         protoErr
);

  localparam int MOD_W = $clog2(DATA_W / 8);

  ctlStrobe_t           ctl;
  logic                 parityBad;
  logic                 bufValid;
  logic [ERR_COUNT-1:0] errFlags;

  pkt_rx_ctrl #(.MOD_W(MOD_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .laneMode8 (laneMode8),
    .inValid   (inValid),
    .inSop     (inSop),
    .inEop     (inEop),
    .inMod     (inMod),
    .parityBad (parityBad),
    .bufValid  (bufValid),
    .outReady  (outReady),
    .errClear  (errClear),
    .inReady   (inReady),
    .ctl       (ctl),
    .errFlags  (errFlags)
  );

  pkt_rx_datapath #(.DATA_W(DATA_W), .EVEN_PARITY(EVEN_PARITY)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .laneMode8 (laneMode8),
    .inData    (inData),
    .inMod     (inMod),
    .inParity  (inParity),
    .ctl       (ctl),
    .parityBad (parityBad),
    .bufValid  (bufValid),
    .outByte   (outByte),
    .outFirst  (outFirst),
    .outLast   (outLast)
  );

  assign outValid   = bufValid;
  assign parityErr  = errFlags[ERR_PARITY];
  assign framingErr = errFlags[ERR_FRAME];
  assign protoErr   = errFlags[ERR_PROTO];

endmodule

// File: rtl/pkt_rx_unpacker_chk.sv
module pkt_rx_unpacker_chk #(
  parameter int DATA_W      = 32,
  parameter int EVEN_PARITY = 0
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         laneMode8,
  input logic [DATA_W-1:0]            inData,
  input logic                         inValid,
  input logic                         inSop,
  input logic                         inEop,
  input logic [$clog2(DATA_W/8)-1:0]  inMod,
  input logic                         inParity,
  input logic                         inReady,
  input logic [7:0]                   outByte,
  input logic                         outValid,
  input logic                         outFirst,
  input logic                         outLast,
  input logic                         outReady,
  input logic [2:0]                   errClear,
  input logic                         parityErr,
  input logic                         framingErr,
  input logic                         protoErr
);

  logic take;
  logic wordPar;
  assign take    = inValid && inReady;
  assign wordPar = laneMode8 ? ^inData[7:0] : ^inData;

  a_r1_start_word_loads: assert property (@(posedge clk) disable iff (!rstN)
    (take && inSop) |=> (outValid && !inReady));

  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outByte) && $stable(outFirst) && $stable(outLast)));

  a_r4_mod_on_middle_word: assert property (@(posedge clk) disable iff (!rstN)
    (take && !laneMode8 && !inEop && inMod != '0) |=> protoErr);

  a_r5_narrow_no_proto: assert property (@(posedge clk) disable iff (!rstN)
    (laneMode8 && !protoErr) |=> !protoErr);

  a_r5_narrow_single_byte: assert property (@(posedge clk) disable iff (!rstN)
    (take && laneMode8 && inSop && inEop) |=> (outFirst && outLast));

  a_r6_first_marked: assert property (@(posedge clk) disable iff (!rstN)
    (take && inSop) |=> outFirst);

  a_r7_parity_fault: assert property (@(posedge clk) disable iff (!rstN)
    (take && ((wordPar ^ inParity) == (EVEN_PARITY != 0))) |=> parityErr);

  a_r9_parity_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr && !errClear[0]) |=> parityErr);

  a_r9_framing_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (framingErr && !errClear[1]) |=> framingErr);

endmodule

bind pkt_rx_unpacker pkt_rx_unpacker_chk #(.DATA_W(DATA_W), .EVEN_PARITY(EVEN_PARITY)) u_chk (
  .clk(clk), .rstN(rstN), .laneMode8(laneMode8), .inData(inData), .inValid(inValid),
  .inSop(inSop), .inEop(inEop), .inMod(inMod), .inParity(inParity), .inReady(inReady),
  .outByte(outByte), .outValid(outValid), .outFirst(outFirst), .outLast(outLast),
  .outReady(outReady), .errClear(errClear), .parityErr(parityErr),
  .framingErr(framingErr), .protoErr(protoErr)
);

// File: tb/pkt_rx_unpacker_tb.sv
module pkt_rx_unpacker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        laneMode8 = 1'b0;
  logic [31:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inSop = 1'b0;
  logic        inEop = 1'b0;
  logic [1:0]  inMod = '0;
  logic        inParity = 1'b0;
  logic        inReady;
  logic [7:0]  outByte;
  logic        outValid;
  logic        outFirst;
  logic        outLast;
  logic        outReady = 1'b0;
  logic [2:0]  errClear = '0;
  logic        parityErr;
  logic        framingErr;
  logic        protoErr;

  always #5 clk = ~clk;

  pkt_rx_unpacker u_dut (.*);

  typedef struct {
    logic [7:0] b;
    bit         f;
    bit         l;
    bit         narrow;
  } ent_t;

  ent_t     q[$];
  bit       mOpen;
  bit [2:0] mErr;
  int       nChecks = 0;
  int       nFail = 0;
  bit       finished = 0;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  task automatic compare();
    chk("R1 inReady", int'(inReady), int'(q.size() == 0));
    chk("R2 outValid", int'(outValid), int'(q.size() != 0));
    if (q.size() != 0) begin
      chk(q[0].narrow ? "R5 narrow byte" : "R3 byte", int'(outByte), int'(q[0].b));
      chk("R6 outFirst", int'(outFirst), int'(q[0].f));
      chk("R6 outLast", int'(outLast), int'(q[0].l));
    end
    chk("R7,R9 parityErr", int'(parityErr), int'(mErr[0]));
    chk("R8,R9 framingErr", int'(framingErr), int'(mErr[1]));
    chk("R4,R9 protoErr", int'(protoErr), int'(mErr[2]));
  endtask

  task automatic drive_random(bit narrow);
    bit dp;
    laneMode8 = narrow;
    inValid   = ($urandom % 4) != 0;
    inSop     = mOpen ? (($urandom % 20) == 0) : (($urandom % 10) != 0);
    inEop     = ($urandom % 4) == 0;
    if (inEop || ($urandom % 20) == 0) inMod = 2'($urandom);
    else inMod = 2'd0;
    inData    = $urandom;
    dp        = narrow ? ^inData[7:0] : ^inData;
    inParity  = (($urandom % 12) == 0) ? dp : ~dp;
    outReady  = ($urandom % 3) != 0;
    errClear  = {3{1'b0}};
    for (int k = 0; k < 3; k++) errClear[k] = ($urandom % 8) == 0;
  endtask

  // reference update for the coming edge, from the inputs now applied
  task automatic model_step();
    bit [2:0] setv;
    bit acc;
    bit dp;
    int n;
    setv = '0;
    acc  = inValid && (q.size() == 0);
    if (q.size() != 0 && outReady) void'(q.pop_front());
    if (acc) begin
      dp = laneMode8 ? ^inData[7:0] : ^inData;
      if ((dp ^ inParity) == 1'b0) setv[0] = 1;               // odd parity expected
      if ((inSop && mOpen) || (!inSop && !mOpen)) setv[1] = 1;
      if (!laneMode8 && !inEop && inMod != 0) setv[2] = 1;
      if (inSop || mOpen) begin
        n = laneMode8 ? 1 : (inEop ? 4 - int'(inMod) : 4);
        for (int j = 0; j < n; j++) begin
          ent_t e;
          e.b      = laneMode8 ? inData[7:0] : inData[31 - 8*j -: 8];
          e.f      = inSop && (j == 0);
          e.l      = inEop && (j == n - 1);
          e.narrow = laneMode8;
          q.push_back(e);
        end
        mOpen = !inEop;
      end
    end
    mErr = (mErr & ~errClear) | setv;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    mOpen = 0;
    mErr  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10 outValid", int'(outValid), 0);
    chk("R10 inReady", int'(inReady), 1);
    chk("R10 errors", int'({parityErr, framingErr, protoErr}), 0);
    rstN = 1'b1;
    // first cycle: a clean single-word packet with every byte valid
    laneMode8 = 0; inValid = 1; inSop = 1; inEop = 1; inMod = 0;
    inData = 32'hA1B2C3D4; inParity = ~(^inData); outReady = 1; errClear = '0;
    model_step();
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      compare();
      drive_random(cyc >= 3000 && cyc < 4500);
      model_step();
    end
    @(negedge clk);
    compare();
    finish_run();
  end

endmodule